// File: doc/BRIEF.md
# Nibble-Decomposed Unsigned Multiplier

This block multiplies two unsigned binary operands combinationally. Each operand is split into a high half and a low half, called nibbles at the default width. Four small array multipliers form the four cross products of those halves. A short chain of three-input adders then merges the cross products into the full-width product, one nibble at a time.

Each small multiplier is a square array of AND gates feeding rows of full adders. Each three-input adder first compresses its three nibbles with a row of full adders into a sum vector and a carry vector. A carry-propagate adder then adds the two, with the carry vector offset by one bit. The carry passed between nibble stages is two bits wide, because three nibbles plus an incoming carry can overflow by up to two.

The nibble width is a parameter and defaults to 4, which gives an 8x8 to 16-bit multiplier. A second parameter selects how the carry-propagate adder inside each three-input adder resolves its carries: a ripple chain, or flattened two-level lookahead terms.

Top module: `nib_mult`

## Requirements
- R1: For every pair of unsigned 8-bit operands, `prod` equals the unsigned integer product `opa * opb` as a 16-bit unsigned binary number.
- R2: `prod[3:0]` equals the low 4 bits of the product of the two operands' low nibbles (`opa[3:0] * opb[3:0]`).
- R3: When both high nibbles are zero, `prod` equals the low-nibble product, which never exceeds 225.
- R4: The carry passed between nibble stages never exceeds 2. The worst case, 255 x 255, yields 65025 (0xFE01).
- R5: The most significant nibble stage never produces a carry beyond bit 15.
- R6: When either operand is zero, `prod` is zero.
- R7: When one operand is 1, `prod` equals the other operand, zero-extended.
- R8: 13 x 11 yields 143, and 0xD0 x 0xB0 yields 36608 (143 shifted left by 8).
- R9: The ripple and lookahead carry variants produce identical products for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | Multiplicand, unsigned binary |
| opb | input | 8 | Multiplier, unsigned binary |
| prod | output | 16 | Unsigned product |

## Verification
The assertions assume that both operands are settled, two-state values whenever the combinational checks evaluate. They also assume that the two-bit carry into any three-input adder comes from the previous nibble stage, so it never takes the value 3. The bench changes the operands just after a rising edge and reads `prod` at the following falling edge, so every check sees settled logic. It sweeps all 65536 operand pairs through one instance of each carry variant, so the inter-stage carries are only ever produced by the design itself.

// File: rtl/nib_mult_pkg.sv
package nib_mult_pkg;
   // Inter-stage carry: value 0, 1 or 2 in plain binary
   typedef logic [1:0] stage_carry_t;
   localparam int unsigned CARRY_MAX = 2;
   // Carry-propagate adder variants
   localparam int unsigned CPA_RIPPLE    = 0;
   localparam int unsigned CPA_LOOKAHEAD = 1;
endpackage

// File: rtl/nib_fa.sv
module nib_fa (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic hx;
   assign hx = x ^ y;
   assign s  = hx ^ ci;
   assign co = (x & y) | (ci & hx);
endmodule

// File: rtl/nib_array_mul.sv
module nib_array_mul #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   localparam int unsigned PMAX = ((1 << W) - 1) * ((1 << W) - 1);

   if (W < 2) begin : g_bad_w
      $error("nib_array_mul: W must be at least 2");
   end

   logic [W-1:0][W-1:0] pp;

   for (genvar r = 0; r < W; r++) begin : g_and_r
      for (genvar i = 0; i < W; i++) begin : g_and_i
         assign pp[r][i] = a[i] & b[r];
      end
   end

   for (genvar r = 0; r < W; r++) begin : row
      logic [W-1:0] up;
      if (r == 0) begin : g_first
         assign p[0] = pp[0][0];
         assign up   = {1'b0, pp[0][W-1:1]};
      end else begin : g_add
         logic [W-1:0] s;
         logic [W:0]   c;
         assign c[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_cell
            nib_fa u_fa (
               .x (pp[r][i]),
               .y (row[r-1].up[i]),
               .ci(c[i]),
               .s (s[i]),
               .co(c[i+1])
            );
         end
         assign p[r] = s[0];
         assign up   = {c[W], s[W-1:1]};
      end
   end

   assign p[2*W-1:W] = row[W-1].up;

   always_comb begin
      if (a == '0 || b == '0) begin
         assert_pp_zero_R6 : assert (p == '0);
      end
      assert_pp_range_R3 : assert (32'(p) <= PMAX);
   end
endmodule

// File: rtl/nib_add3.sv
module nib_add3
   import nib_mult_pkg::*;
#(
   parameter int unsigned W   = 4,
   parameter int unsigned CPA = CPA_RIPPLE
) (
   input  logic [W-1:0]  x,
   input  logic [W-1:0]  y,
   input  logic [W-1:0]  z,
   input  stage_carry_t  cin,
   output logic [W-1:0]  sum,
   output stage_carry_t  cout
);
   localparam int unsigned N = W + 1;

   if (W < 2) begin : g_bad_w
      $error("nib_add3: W must be at least 2");
   end
   if (CPA != CPA_RIPPLE && CPA != CPA_LOOKAHEAD) begin : g_bad_cpa
      $error("nib_add3: unknown carry-propagate variant");
   end

   // Carry-save row
   logic [W-1:0] sv, cv;
   for (genvar i = 0; i < W; i++) begin : g_csa
      nib_fa u_fa (.x(x[i]), .y(y[i]), .ci(z[i]), .s(sv[i]), .co(cv[i]));
   end

   // A carry of value 2 becomes two unit carries: one fills the
   // empty slot of the shifted carry vector, one enters the CPA.
   logic ci_slot, ci_cpa;
   assign ci_slot = cin[0] | cin[1];
   assign ci_cpa  = cin[1];

   logic [N-1:0] opx, opy, g, pr;
   logic [N:0]   cc;
   assign opx = {1'b0, sv};
   assign opy = {cv, ci_slot};
   assign g   = opx & opy;
   assign pr  = opx ^ opy;

   if (CPA == CPA_RIPPLE) begin : g_ripple
      assign cc[0] = ci_cpa;
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign cc[i+1] = g[i] | (pr[i] & cc[i]);
      end
   end else begin : g_lookahead
      always_comb begin
         logic acc, term;
         cc[0] = ci_cpa;
         for (int i = 0; i < N; i++) begin
            term = ci_cpa;
            for (int j = 0; j <= i; j++) term = term & pr[j];
            acc = term;
            for (int j = 0; j <= i; j++) begin
               term = g[j];
               for (int k = j + 1; k <= i; k++) term = term & pr[k];
               acc = acc | term;
            end
            cc[i+1] = acc;
         end
      end
   end

   logic [N-1:0] res;
   assign res  = pr ^ cc[N-1:0];
   assign sum  = res[W-1:0];
   assign cout = {cc[N], res[W]};

   always_comb begin
      assert_cin_legal_R4 : assert (cin <= stage_carry_t'(CARRY_MAX));
      assert_cout_legal_R4 : assert (cout <= stage_carry_t'(CARRY_MAX));
      assert_sum_exact_R4 : assert ({cout, sum} ==
         (W+2)'(x) + (W+2)'(y) + (W+2)'(z) + (W+2)'(cin));
   end
endmodule

// File: rtl/nib_mult.sv
module nib_mult
   import nib_mult_pkg::*;
#(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned CPA   = CPA_RIPPLE
) (
   input  logic [2*NIB_W-1:0] opa,
   input  logic [2*NIB_W-1:0] opb,
   output logic [4*NIB_W-1:0] prod
);
   localparam int unsigned W  = NIB_W;
   localparam int unsigned SW = 2 * NIB_W;
   localparam int unsigned PW = 4 * NIB_W;

   if (NIB_W < 2 || NIB_W > 8) begin : g_bad_w
      $error("nib_mult: NIB_W must lie in 2..8");
   end

   // Sub-products: index bit 0 picks the opa half, bit 1 the opb half
   logic [3:0][SW-1:0] pp;
   for (genvar k = 0; k < 4; k++) begin : g_pp
      localparam int unsigned AOFF = (k % 2) * W;
      localparam int unsigned BOFF = (k / 2) * W;
      nib_array_mul #(.W(W)) u_arr (
         .a(opa[AOFF +: W]),
         .b(opb[BOFF +: W]),
         .p(pp[k])
      );
   end

   stage_carry_t c1, c2, c3;

   assign prod[W-1:0] = pp[0][W-1:0];

   nib_add3 #(.W(W), .CPA(CPA)) u_stage1 (
      .x(pp[0][SW-1:W]), .y(pp[1][W-1:0]), .z(pp[2][W-1:0]),
      .cin(2'd0), .sum(prod[2*W-1:W]), .cout(c1)
   );

   nib_add3 #(.W(W), .CPA(CPA)) u_stage2 (
      .x(pp[1][SW-1:W]), .y(pp[2][SW-1:W]), .z(pp[3][W-1:0]),
      .cin(c1), .sum(prod[3*W-1:2*W]), .cout(c2)
   );

   nib_add3 #(.W(W), .CPA(CPA)) u_stage3 (
      .x(pp[3][SW-1:W]), .y('0), .z('0),
      .cin(c2), .sum(prod[PW-1:3*W]), .cout(c3)
   );

   always_comb begin
      assert_no_overflow_R5 : assert (c3 == 2'd0);
      assert_product_R1 : assert (prod == PW'(opa) * PW'(opb));
      if (opa == SW'(1)) begin
         assert_unit_a_R7 : assert (prod == PW'(opb));
      end
      if (opb == SW'(1)) begin
         assert_unit_b_R7 : assert (prod == PW'(opa));
      end
   end
endmodule

// File: tb/tb_nib_mult.sv
module tb_nib_mult;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [7:0]  opa = '0, opb = '0;
   logic [15:0] prod, prod_alt;
   int tests = 0, fails = 0;

   nib_mult dut (.opa(opa), .opb(opb), .prod(prod));
   nib_mult #(.CPA(1)) dut_alt (.opa(opa), .opb(opb), .prod(prod_alt));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tag, opa, opb, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] a, input logic [7:0] b);
      @(posedge clk);
      opa <= a;
      opb <= b;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      rst <= 1'b0;
      @(negedge clk);
      check("R6 reset state", prod, 16'd0);

      apply(8'd13, 8'd11);   check("R8", prod, 16'd143);
      apply(8'hD0, 8'hB0);   check("R8", prod, 16'd36608);
      apply(8'h7B, 8'hE5);   check("R2", {12'd0, prod[3:0]}, 16'((4'hB * 4'h5) & 4'hF));
      apply(8'h0F, 8'h0F);   check("R3", prod, 16'd225);
      apply(8'h09, 8'h07);   check("R3", prod, 16'd63);
      apply(8'hFF, 8'hFF);   check("R4", prod, 16'hFE01);
      apply(8'hFF, 8'hFF);   check("R5", {12'd0, prod[15:12]}, 16'hF);
      apply(8'd0, 8'hC3);    check("R6", prod, 16'd0);
      apply(8'hC3, 8'd0);    check("R6", prod, 16'd0);
      apply(8'd1, 8'hA7);    check("R7", prod, 16'h00A7);
      apply(8'hFE, 8'd1);    check("R7", prod, 16'h00FE);

      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            apply(8'(i), 8'(j));
            check("R1", prod, 16'(i * j));
            check("R9", prod_alt, 16'(i * j));
         end
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule